// File: doc/BRIEF.md
# Serial Bit-Population Counter

This block counts the set bits of a data word one bit at a time. A one-cycle `start` pulse, given while the block is idle, captures `din` in a working shift register and presets the result register to all ones. The word then leaves the shift register MSB first through a single flag flip-flop. Each time the flag holds a 1, the result register increments. The first increment is unconditional and wraps the preset value to zero, so no separate clear step is needed.

The run ends as soon as the working register holds only zeros, so a word whose low bits are clear finishes early. When the run ends the block returns to idle and raises `done`. `done` and `count` then hold their values until the next accepted `start`. A four-state controller sequences the work. Its state sits in two flip-flops and is decoded into four phase lines. The next-state value is built by one multiplexer per state bit, and the current state drives the select of each multiplexer.

Top module: `bitcount_serial`

## Requirements
- R1: After reset the block is idle, with `busy`=0, `done`=0 and `count`=0.
- R2: When `start`=1 is sampled in idle, the working register loads `din`, the result register is set to all ones and the controller enters the increment state (encoding 01). `busy` is 1 after that edge.
- R3: When `start`=0 is sampled in idle, the controller stays in idle (encoding 00). `count` and `done` do not change.
- R4: In the increment state the result register adds one. The next state is idle if the working register is all zeros, and the shift state (encoding 10) otherwise.
- R5: In the shift state the working register shifts left by one bit: its MSB goes into the flag and a 0 enters at the LSB. The next state is always the test state (encoding 11).
- R6: In the test state the next state is increment when the flag is 1, and shift when the flag is 0.
- R7: At `done`, `count` equals the number of 1 bits in the captured word. It is 0 for an all-zero word and W for an all-ones word, and it never exceeds W after an increment.
- R8: An all-zero word sets `done` 1 cycle after the start edge. Any other word sets it 1 + popcount + 2·(W − i) cycles after the start edge, where i is the index of its lowest set bit.
- R9: `done` rises only on the move from increment to idle. It stays high, with `count` held, until the next accepted `start` clears it.
- R10: A `start` pulse while `busy`=1 has no effect on the run or on its result.
- R11: Exactly one of the four decoded phase lines is active in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; synchronised internally for release |
| start | input | 1 | Begin a count; honoured only in idle |
| din | input | W | Word to be counted |
| count | output | CW = ceil(log2(W+1)) | Result register |
| busy | output | 1 | Controller is outside idle |
| done | output | 1 | Result valid; set when a run ends |

## Verification
The bench builds the block with its default W = 8, which makes the result register 4 bits wide. At this width the all-ones word drives the count to 8 = 1000b, so every bit of the result register is exercised. The same width also tests the wrap from the 1111b preset to zero on the first increment. The vector set covers words whose lowest set bit sits at the LSB, at the MSB and in between, so each measured latency pins down the number of shift/test passes. It also shows that the early exit works.

// File: rtl/bitcount_pkg.sv
package bitcount_pkg;

  // Controller state encoding; the per-bit next-state multiplexers rely on it.
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_INC  = 2'b01,
    PH_SHF  = 2'b10,
    PH_TST  = 2'b11
  } phase_e;

  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned PH_BITS    = 2;

endpackage

// File: rtl/bitcount_rst_sync.sv
module bitcount_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bitcount_nsel.sv
// Next-state logic: one 4:1 multiplexer per state bit, selected by the present state.
module bitcount_nsel
  import bitcount_pkg::*;
(
  input  phase_e             cur,
  input  logic               start,
  input  logic               zero,
  input  logic               e_bit,
  output logic [PH_BITS-1:0] nxt
);

  // mux_in[bit][sel]: data input 'sel' of the multiplexer for state bit 'bit'
  logic [NUM_PHASES-1:0] mux_in [PH_BITS];

  always_comb begin
    // bit 0 (low state bit)
    mux_in[0][PH_IDLE] = start;
    mux_in[0][PH_INC]  = 1'b0;
    mux_in[0][PH_SHF]  = 1'b1;
    mux_in[0][PH_TST]  = e_bit;
    // bit 1 (high state bit)
    mux_in[1][PH_IDLE] = 1'b0;
    mux_in[1][PH_INC]  = ~zero;
    mux_in[1][PH_SHF]  = 1'b1;
    mux_in[1][PH_TST]  = ~e_bit;
  end

  for (genvar b = 0; b < PH_BITS; b++) begin : g_mux
    assign nxt[b] = mux_in[b][cur];
  end

endmodule

// File: rtl/bitcount_ctrl.sv
module bitcount_ctrl
  import bitcount_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  zero,
  input  logic                  e_bit,
  output logic [NUM_PHASES-1:0] phase_t,
  output phase_e                state,
  output logic                  done
);

  phase_e             state_q;
  logic [PH_BITS-1:0] nxt;
  logic               done_d, done_q;

  bitcount_nsel u_nsel (
    .cur   (state_q),
    .start (start),
    .zero  (zero),
    .e_bit (e_bit),
    .nxt   (nxt)
  );

  // Decoder: state bits to phase lines T0..T3
  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_dec
    assign phase_t[p] = (state_q == phase_e'(p));
  end

  always_comb begin
    done_d = done_q;
    if (phase_t[PH_IDLE] && start)    done_d = 1'b0;
    else if (phase_t[PH_INC] && zero) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= phase_e'(nxt);
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;

  a_r11_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase_t) == 1);
  a_r2_start_to_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_t[PH_IDLE] && start) |=> (state_q == PH_INC));
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_t[PH_IDLE] && !start) |=> (state_q == PH_IDLE) && $stable(done_q));
  a_r4_inc_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_t[PH_INC] && zero) |=> (state_q == PH_IDLE));
  a_r4_inc_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_t[PH_INC] && !zero) |=> (state_q == PH_SHF));
  a_r5_shf_to_tst: assert property (@(posedge clk) disable iff (!rst_n)
    phase_t[PH_SHF] |=> (state_q == PH_TST));
  a_r6_tst_one: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_t[PH_TST] && e_bit) |=> (state_q == PH_INC));
  a_r6_tst_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_t[PH_TST] && !e_bit) |=> (state_q == PH_SHF));
  a_r9_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(state_q) == PH_INC) && (state_q == PH_IDLE));

endmodule

// File: rtl/bitcount_dpath.sv
module bitcount_dpath #(
  parameter int unsigned W  = 8,
  parameter int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          inc_en,
  input  logic          shf_en,
  input  logic [W-1:0]  din,
  output logic          zero,
  output logic          e_bit,
  output logic [CW-1:0] count
);

  logic [W-1:0]  r1_d, r1_q;
  logic          e_d, e_q;
  logic [CW-1:0] r2_d, r2_q;

  // Working register: parallel load or left shift
  always_comb begin
    r1_d = r1_q;
    if (load_en)     r1_d = din;
    else if (shf_en) r1_d = {r1_q[W-2:0], 1'b0};
  end

  // Flag flip-flop catches the bit leaving the MSB
  always_comb begin
    e_d = e_q;
    if (shf_en) e_d = r1_q[W-1];
  end

  // Result register: preset to all ones, then count up
  always_comb begin
    r2_d = r2_q;
    if (load_en)     r2_d = '1;
    else if (inc_en) r2_d = r2_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= '0;
      e_q  <= 1'b0;
      r2_q <= '0;
    end else begin
      r1_q <= r1_d;
      e_q  <= e_d;
      r2_q <= r2_d;
    end
  end

  assign zero  = ~|r1_q;
  assign e_bit = e_q;
  assign count = r2_q;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (r2_q == {CW{1'b1}}) && (r1_q == $past(din)));
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !load_en) |=> (r1_q == {$past(r1_q[W-2:0]), 1'b0}) && (e_q == $past(r1_q[W-1])));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    inc_en |=> (r2_q <= CW'(W)));
  a_r4_no_shift_on_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !shf_en && !load_en) |=> $stable(r1_q));

endmodule

// File: rtl/bitcount_serial.sv
module bitcount_serial
  import bitcount_pkg::*;
#(
  parameter int unsigned W  = 8,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  din,
  output logic [CW-1:0] count,
  output logic          busy,
  output logic          done
);

  logic                  rst_sync_n;
  logic                  zero, e_bit;
  logic [NUM_PHASES-1:0] phase_t;
  phase_e                state;

  bitcount_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bitcount_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (start),
    .zero    (zero),
    .e_bit   (e_bit),
    .phase_t (phase_t),
    .state   (state),
    .done    (done)
  );

  bitcount_dpath #(.W(W), .CW(CW)) u_dpath (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (phase_t[PH_IDLE] & start),
    .inc_en  (phase_t[PH_INC]),
    .shf_en  (phase_t[PH_SHF]),
    .din     (din),
    .zero    (zero),
    .e_bit   (e_bit),
    .count   (count)
  );

  assign busy = (state != PH_IDLE);

  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && start && state != PH_INC) |=> busy);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && !start) |=> done && $stable(count));

endmodule

// File: tb/bitcount_serial_bench.sv
module bitcount_serial_bench;

  localparam int unsigned W       = 8;
  localparam int unsigned CW      = $clog2(W + 1);
  localparam time         CLK_PER = 10ns;
  localparam int          NVEC    = 10;
  localparam int          WD_MAX  = 20000;

  localparam logic [W-1:0] VEC_DIN [NVEC] = '{
    8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5, 8'h5A, 8'h0F, 8'hF0, 8'h7E, 8'h81};
  localparam int VEC_CNT [NVEC] = '{0, 8, 1, 1, 4, 4, 4, 4, 6, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  din = '0;
  logic [CW-1:0] count;
  logic          busy, done;

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  bitcount_serial #(.W(W)) u_bitcount_serial (
    .clk(clk), .rst_n(rst_n), .start(start), .din(din),
    .count(count), .busy(busy), .done(done));

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  // R8 latency model
  function automatic int exp_lat(input logic [W-1:0] v);
    int lo = -1;
    if (v == '0) return 1;
    for (int i = W - 1; i >= 0; i--) if (v[i]) lo = i;
    return 1 + popc(v) + 2 * (W - lo);
  endfunction

  // Apply start at a negedge, return cycles from the start edge until done is seen.
  task automatic run(input logic [W-1:0] v, output int lat);
    @(negedge clk); din = v; start = 1'b1;
    @(negedge clk); start = 1'b0; din = ~v;
    lat = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  initial begin : watchdog
    while (cyc_total < WD_MAX) begin
      @(posedge clk);
      cyc_total++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected<%0d", cyc_total, WD_MAX);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int lat;
    logic [CW-1:0] hold;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 count", int'(count), 0);

    // R3 idle without start
    repeat (5) @(negedge clk);
    check("R3 busy", int'(busy), 0);
    check("R3 count", int'(count), 0);

    // Vector table: R2 R4 R5 R6 R7 R8
    for (int n = 0; n < NVEC; n++) begin
      run(VEC_DIN[n], lat);
      check($sformatf("R7 count din=%02h", VEC_DIN[n]), int'(count), VEC_CNT[n]);
      check($sformatf("R8 latency din=%02h", VEC_DIN[n]), lat, exp_lat(VEC_DIN[n]));
    end

    // R9 done and count hold in idle; R3 with done set
    hold = count;
    repeat (6) @(negedge clk);
    check("R9 done held", int'(done), 1);
    check("R9 count held", int'(count), int'(hold));
    check("R3 busy after done", int'(busy), 0);

    // R2 accepted start clears done and raises busy
    @(negedge clk); din = 8'h3C; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R2 busy", int'(busy), 1);
    check("R9 done cleared", int'(done), 0);
    while (!done) @(negedge clk);
    check("R7 count 3C", int'(count), 4);

    // R10 start during a run is ignored
    @(negedge clk); din = 8'h01; start = 1'b1;
    @(negedge clk); din = 8'hFF;
    repeat (3) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R10 count unaffected", int'(count), 1);

    // R1 asynchronous reset mid-run
    @(negedge clk); din = 8'hFF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 count in reset", int'(count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run(8'h40, lat);
    check("R7 count after reset", int'(count), 1);
    check("R8 latency after reset", lat, exp_lat(8'h40));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule